// File: doc/BRIEF.md
# Flash Read-Ahead FIFO Engine

This block reads a contiguous run of 32-bit words from a serial NOR flash and queues them in a small FIFO for the host to collect. Software writes a start address and a word count, then sets a start bit. The engine lowers chip select and shifts out a read opcode and an address. It then waits an optional number of dummy clocks and shifts in data until the programmed number of words has been queued. The host polls a status register and pops one word per read of the data register.

The read format comes from configuration inputs driven by a neighbouring register block. When the format-override input is low, the engine uses a plain single-lane read: opcode 0x03, a 3-byte address and no dummy clocks. When the input is high, the opcode, the lane width of each phase, the dummy clock count and the address length are all programmable. With a 4-byte address the top byte comes from a separate upper-address input. Only the low 24 bits of the start address are used, so one session stays inside a 16 MB window.

If the FIFO fills while a session is running, the engine parks the serial clock low at the next word boundary. It resumes once the host has popped a word, so no flash data is dropped.

Top module: `rafEngine`

## Requirements
- R1: Register reads at byte offsets: 0x00 start address, 0x04 word count, 0x0C FIFO fill level, 0x14 status (bit 0 session busy, bit 1 FIFO empty), 0x18 data, 0x1C words delivered this session, 0x20 current flash address. After reset, status reads 2 and the fill level, the word counters and the data register read 0.
- R2: Writing 1 to bit 0 of offset 0x08 while idle starts a session, provided the word count is non-zero. A start with a zero count does nothing. A start written while busy is ignored, and so is a word count written while busy, for the session already running.
- R3: With format override off, a session sends opcode 0x03 and then start address bits 23:0, MSB first on io0. It uses no dummy clocks and samples data MSB first from io1. The serial clock idles low, and the engine samples on the rising edge and changes outputs on the falling edge.
- R4: With format override on, the opcode comes from the opcode input. The lane-width fields of the bits-per-cycle input hold log2 of the width (0=1, 1=2, 2=4 lanes; other values mean 1 lane): cmd in bits 31:24, address in 23:16, data in 7:0. Bits 7:0 of the bits-per-phase input give the dummy clock count. All output enables are low during the dummy and data phases.
- R5: With format override on and bit 16 of bits-per-phase set, the address is 32 bits, {upper byte, start[23:0]}. The current address advances by 4 per word and wraps within the low 24 bits, so the top byte never changes.
- R6: Each 32-bit word is little-endian: the first byte received lands in bits 7:0. Within each byte, bits arrive MSB first. In multi-lane phases the highest-numbered lane carries the most significant bit of each group.
- R7: Each read of offset 0x18 pops one word. A read while the FIFO is empty returns 0 and changes neither the fill level nor the pointers.
- R8: After the programmed number of words has been queued, busy clears and chip select goes high. The delivered count then equals the word count, and the current address equals the start address plus 4 per word.
- R9: When the FIFO is full at a word boundary, the serial clock is held low until a word is popped. No word is lost or overwritten.
- R10: Chip select is low for the whole session, and the serial clock is never high while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops on data offset) |
| regAddr | input | 6 | Register byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the cycle of regRd |
| flexEn | input | 1 | Format override enable |
| cmdByte | input | 8 | Read opcode used under override |
| bitsPerCycle | input | 32 | Lane-width codes for the cmd, address and data phases |
| bitsPerPhase | input | 32 | Dummy clock count (7:0) and 4-byte enable (16) |
| upperAddr | input | 8 | Address bits 31:24 in 4-byte mode |
| flashSclk | output | 1 | Serial clock |
| flashCsN | output | 1 | Chip select, active low |
| flashIoOut | output | 4 | Serial data out, lanes 3..0 |
| flashIoOe | output | 4 | Output enable per lane |
| flashIoIn | input | 4 | Serial data in, lanes 3..0 |

## Verification
Assertions check on every cycle that the serial clock stays low while chip select is high, and that the clock stays parked while the FIFO-full stall holds. They also check that no word is pushed into a full FIFO, that an empty read leaves the read pointer alone, that lanes are released during the dummy and data phases, and that busy drops right after the last word. Only the bench scenarios can show the rest. These are the bit-level wire format under each lane width (opcode, address length and upper byte), the little-endian byte packing against a flash model, the ignored starts, and the full-FIFO stall followed by a drain that loses no data.

// File: rtl/rafPkg.sv
package rafPkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA
  } phaseT;

  typedef struct packed {
    logic sessBegin;
    logic loadAddr;
    logic shiftTx;
    logic sampleRx;
    logic pushWord;
  } strobeT;

  localparam logic [5:0] OFF_START  = 6'h00;
  localparam logic [5:0] OFF_COUNT  = 6'h04;
  localparam logic [5:0] OFF_CTRL   = 6'h08;
  localparam logic [5:0] OFF_FILL   = 6'h0C;
  localparam logic [5:0] OFF_STATUS = 6'h14;
  localparam logic [5:0] OFF_DATA   = 6'h18;
  localparam logic [5:0] OFF_XFER   = 6'h1C;
  localparam logic [5:0] OFF_CUR    = 6'h20;

  localparam logic [7:0] DEFAULT_OPCODE = 8'h03;

  function automatic logic [1:0] laneCode(input logic [7:0] field);
    return (field > 8'd2) ? 2'd0 : field[1:0];
  endfunction
endpackage

// File: rtl/rafCtrl.sv
module rafCtrl
  import rafPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] wordCnt,
  input  logic             fifoFull,
  input  logic [1:0]       cmdCode,
  input  logic [1:0]       addrCode,
  input  logic [1:0]       dataCode,
  input  logic             fourByte,
  input  logic [7:0]       dummyCyc,
  output strobeT           strb,
  output logic [1:0]       laneLog,
  output logic             sclk,
  output logic             csN,
  output logic [3:0]       oe,
  output logic             busy
);
  phaseT            state;
  logic             half;
  logic [7:0]       cyc;
  logic [CNT_W-1:0] wordsLeft;
  logic [7:0]       cmdLast, addrLast, dataLast;
  logic             stall, endOfCycle;

  assign cmdLast  = (8'd8 >> cmdCode) - 8'd1;
  assign addrLast = ((fourByte ? 8'd32 : 8'd24) >> addrCode) - 8'd1;
  assign dataLast = (8'd32 >> dataCode) - 8'd1;

  assign stall      = (state == S_DATA) && !half && (cyc == dataLast) && fifoFull;
  assign endOfCycle = (state != S_IDLE) && half;

  always_comb begin
    strb           = '0;
    strb.sessBegin = (state == S_IDLE) && startReq && (wordCnt != '0);
    strb.shiftTx   = endOfCycle && (state == S_CMD || state == S_ADDR) && (cyc != 8'd0);
    strb.loadAddr  = endOfCycle && (state == S_CMD) && (cyc == 8'd0);
    strb.sampleRx  = endOfCycle && (state == S_DATA);
    strb.pushWord  = strb.sampleRx && (cyc == 8'd0);
  end

  always_comb begin
    case (state)
      S_CMD:   laneLog = cmdCode;
      S_ADDR:  laneLog = addrCode;
      default: laneLog = dataCode;
    endcase
    oe = 4'b0000;
    if (state == S_CMD || state == S_ADDR) begin
      case (laneLog)
        2'd1:    oe = 4'b0011;
        2'd2:    oe = 4'b1111;
        default: oe = 4'b0001;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      half      <= 1'b0;
      cyc       <= '0;
      wordsLeft <= '0;
    end else if (state == S_IDLE) begin
      if (strb.sessBegin) begin
        state     <= S_CMD;
        half      <= 1'b0;
        cyc       <= cmdLast;
        wordsLeft <= wordCnt;
      end
    end else if (!half) begin
      if (!stall) half <= 1'b1;
    end else begin
      half <= 1'b0;
      if (cyc != 8'd0) begin
        cyc <= cyc - 8'd1;
      end else begin
        case (state)
          S_CMD: begin
            state <= S_ADDR;
            cyc   <= addrLast;
          end
          S_ADDR: begin
            if (dummyCyc != 8'd0) begin
              state <= S_DUMMY;
              cyc   <= dummyCyc - 8'd1;
            end else begin
              state <= S_DATA;
              cyc   <= dataLast;
            end
          end
          S_DUMMY: begin
            state <= S_DATA;
            cyc   <= dataLast;
          end
          default: begin
            if (wordsLeft == CNT_W'(1)) begin
              state <= S_IDLE;
            end else begin
              wordsLeft <= wordsLeft - CNT_W'(1);
              cyc       <= dataLast;
            end
          end
        endcase
      end
    end
  end

  assign sclk = half;
  assign csN  = (state == S_IDLE);
  assign busy = (state != S_IDLE);

  p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  p_stall_park_r9: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (!sclk && $stable(cyc)));
  p_end_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pushWord && wordsLeft == CNT_W'(1)) |=> (!busy && csN));
  p_lanes_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DUMMY || state == S_DATA) |-> (oe == 4'b0000));
endmodule

// File: rtl/rafDatapath.sv
module rafDatapath
  import rafPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [5:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  strobeT           strb,
  input  logic [1:0]       laneLog,
  input  logic             busy,
  input  logic [7:0]       opcode,
  input  logic             fourByte,
  input  logic [7:0]       upperAddr,
  output logic [3:0]       ioOut,
  input  logic [3:0]       ioIn,
  output logic             startReq,
  output logic [CNT_W-1:0] wordCnt,
  output logic             fifoFull
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0]      startAddr, curAddr, txShift, rxBits, nextRx, pushData;
  logic [CNT_W-1:0] xferCnt;
  logic [31:0]      mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic             pop, fifoEmpty;
  logic             unusedWdata;

  assign unusedWdata = ^regWdata;
  assign startReq  = regWr && (regAddr == OFF_CTRL) && regWdata[0];
  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == (AW+1)'(DEPTH));
  assign pop       = regRd && (regAddr == OFF_DATA) && !fifoEmpty;

  always_comb begin
    case (laneLog)
      2'd1:    nextRx = {rxBits[29:0], ioIn[1:0]};
      2'd2:    nextRx = {rxBits[27:0], ioIn[3:0]};
      default: nextRx = {rxBits[30:0], ioIn[1]};
    endcase
    pushData = {nextRx[7:0], nextRx[15:8], nextRx[23:16], nextRx[31:24]};
    case (laneLog)
      2'd1:    ioOut = {2'b00, txShift[31:30]};
      2'd2:    ioOut = txShift[31:28];
      default: ioOut = {3'b000, txShift[31]};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startAddr <= '0;
      wordCnt   <= '0;
      txShift   <= '0;
      rxBits    <= '0;
      xferCnt   <= '0;
      curAddr   <= '0;
    end else begin
      if (regWr && !busy && regAddr == OFF_START) startAddr <= regWdata;
      if (regWr && !busy && regAddr == OFF_COUNT) wordCnt <= regWdata[CNT_W-1:0];
      if (strb.sessBegin) begin
        txShift <= {opcode, 24'h0};
        xferCnt <= '0;
        curAddr <= {fourByte ? upperAddr : 8'h00, startAddr[23:0]};
      end else if (strb.loadAddr) begin
        txShift <= fourByte ? {upperAddr, startAddr[23:0]} : {startAddr[23:0], 8'h00};
      end else if (strb.shiftTx) begin
        txShift <= txShift << (6'd1 << laneLog);
      end
      if (strb.sampleRx) rxBits <= nextRx;
      if (strb.pushWord) begin
        xferCnt <= xferCnt + CNT_W'(1);
        curAddr <= {curAddr[31:24], curAddr[23:0] + 24'd4};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.pushWord && !fifoFull) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.pushWord && !fifoFull)
        wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + AW'(1);
      if (pop)
        rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + AW'(1);
      case ({strb.pushWord && !fifoFull, pop})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    regRdata = 32'h0;
    if (regRd) begin
      case (regAddr)
        OFF_START:  regRdata = startAddr;
        OFF_COUNT:  regRdata = 32'(wordCnt);
        OFF_FILL:   regRdata = 32'(count);
        OFF_STATUS: regRdata = {30'h0, fifoEmpty, busy};
        OFF_DATA:   regRdata = fifoEmpty ? 32'h0 : mem[rdPtr];
        OFF_XFER:   regRdata = 32'(xferCnt);
        OFF_CUR:    regRdata = curAddr;
        default:    regRdata = 32'h0;
      endcase
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushWord |-> (count < (AW+1)'(DEPTH)));
  p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    count <= (AW+1)'(DEPTH));
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == OFF_DATA && fifoEmpty) |=> $stable(rdPtr));
endmodule

// File: rtl/rafEngine.sv
module rafEngine
  import rafPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [5:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        flexEn,
  input  logic [7:0]  cmdByte,
  input  logic [31:0] bitsPerCycle,
  input  logic [31:0] bitsPerPhase,
  input  logic [7:0]  upperAddr,
  output logic        flashSclk,
  output logic        flashCsN,
  output logic [3:0]  flashIoOut,
  output logic [3:0]  flashIoOe,
  input  logic [3:0]  flashIoIn
);
  strobeT           strb;
  logic [1:0]       laneLog, cmdCode, addrCode, dataCode;
  logic             fourByte, busy, startReq, fifoFull;
  logic [7:0]       opcode, dummyCyc;
  logic [CNT_W-1:0] wordCnt;
  logic             unusedCfg;

  assign unusedCfg = ^{bitsPerCycle[15:8], bitsPerPhase[31:17], bitsPerPhase[15:8]};
  assign cmdCode   = flexEn ? laneCode(bitsPerCycle[31:24]) : 2'd0;
  assign addrCode  = flexEn ? laneCode(bitsPerCycle[23:16]) : 2'd0;
  assign dataCode  = flexEn ? laneCode(bitsPerCycle[7:0])   : 2'd0;
  assign fourByte  = flexEn && bitsPerPhase[16];
  assign dummyCyc  = flexEn ? bitsPerPhase[7:0] : 8'd0;
  assign opcode    = flexEn ? cmdByte : DEFAULT_OPCODE;

  rafCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wordCnt(wordCnt),
    .fifoFull(fifoFull), .cmdCode(cmdCode), .addrCode(addrCode),
    .dataCode(dataCode), .fourByte(fourByte), .dummyCyc(dummyCyc),
    .strb(strb), .laneLog(laneLog), .sclk(flashSclk), .csN(flashCsN),
    .oe(flashIoOe), .busy(busy)
  );

  rafDatapath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb), .laneLog(laneLog),
    .busy(busy), .opcode(opcode), .fourByte(fourByte), .upperAddr(upperAddr),
    .ioOut(flashIoOut), .ioIn(flashIoIn), .startReq(startReq),
    .wordCnt(wordCnt), .fifoFull(fifoFull)
  );
endmodule

// File: tb/rafEngine_bench.sv
module rafEngine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        flexEn = 1'b0;
  logic [7:0]  cmdByte = 8'h00;
  logic [31:0] bitsPerCycle = '0, bitsPerPhase = '0;
  logic [7:0]  upperAddr = 8'h00;
  logic        flashSclk, flashCsN;
  logic [3:0]  flashIoOut, flashIoOe;
  logic [3:0]  flashIoIn = 4'h0;

  int tests = 0, failed = 0;
  int csViolations = 0, csFalls = 0;
  int mCmdLog = 0, mAddrLog = 0, mDataLog = 0, mAddrBits = 24, mDummy = 0;
  int edgeCnt = 0;
  logic [31:0] capCmd = '0, capAddr = '0;

  always #2.5 clk = ~clk;

  rafEngine u_rafEngine (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .flexEn(flexEn), .cmdByte(cmdByte),
    .bitsPerCycle(bitsPerCycle), .bitsPerPhase(bitsPerPhase), .upperAddr(upperAddr),
    .flashSclk(flashSclk), .flashCsN(flashCsN), .flashIoOut(flashIoOut),
    .flashIoOe(flashIoOe), .flashIoIn(flashIoIn)
  );

  function automatic logic [7:0] flashByte(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ a[31:24] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] laneBits(input logic [3:0] io, input int lg);
    if (lg == 2) return 32'(io);
    if (lg == 1) return 32'(io[1:0]);
    return 32'(io[0]);
  endfunction

  // Flash model: captures opcode and address, then serves data bytes.
  always @(negedge flashCsN or posedge flashSclk) begin
    if (!flashSclk) begin
      edgeCnt = 0; capCmd = '0; capAddr = '0;
    end else begin
      if (edgeCnt < (8 >> mCmdLog))
        capCmd = (capCmd << (1 << mCmdLog)) | laneBits(flashIoOut, mCmdLog);
      else if (edgeCnt < (8 >> mCmdLog) + (mAddrBits >> mAddrLog))
        capAddr = (capAddr << (1 << mAddrLog)) | laneBits(flashIoOut, mAddrLog);
      edgeCnt = edgeCnt + 1;
    end
  end

  always @(negedge flashSclk) begin
    #1;
    if (!flashCsN) begin
      int pre, k, w, perByte, pos;
      logic [7:0] b, bits;
      pre = (8 >> mCmdLog) + (mAddrBits >> mAddrLog) + mDummy;
      if (edgeCnt >= pre) begin
        k = edgeCnt - pre;
        w = 1 << mDataLog;
        perByte = 8 >> mDataLog;
        pos = k % perByte;
        b = flashByte(capAddr + 32'(k / perByte));
        bits = (b >> (8 - w * (pos + 1))) & 8'((1 << w) - 1);
        if (mDataLog == 0) flashIoIn = {2'b00, bits[0], 1'b0};
        else flashIoIn = bits[3:0];
      end
    end
  end

  always @(negedge clk) begin
    if (flashCsN && flashSclk) csViolations++;
  end
  always @(negedge flashCsN) csFalls++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      regRead(6'h14, s);
      if (!s[0]) break;
    end
  endtask

  task automatic popWord(output logic [31:0] d);
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      regRead(6'h14, s);
      if (!s[1]) break;
    end
    regRead(6'h18, d);
  endtask

  task automatic checkWords(input string req, input logic [31:0] base, input int n);
    logic [31:0] d, e;
    for (int i = 0; i < n; i++) begin
      popWord(d);
      for (int j = 0; j < 4; j++) e[j*8 +: 8] = flashByte(base + 32'(4*i + j));
      check(req, d, e);
    end
  endtask

  task automatic runSession(input logic [31:0] start, input int n);
    regWrite(6'h00, start);
    regWrite(6'h04, 32'(n));
    regWrite(6'h08, 32'h1);
    waitIdle();
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRead(6'h14, d); check("R1 status after reset", d, 32'h2);
    regRead(6'h0C, d); check("R1 fill after reset", d, 0);
    regRead(6'h1C, d); check("R1 xfer after reset", d, 0);
    regRead(6'h18, d); check("R1 data after reset", d, 0);
    check("R10 cs idle", 32'(flashCsN), 1);
  endtask

  task automatic testDefaultRead();
    logic [31:0] d;
    flexEn = 0; mCmdLog = 0; mAddrLog = 0; mDataLog = 0; mAddrBits = 24; mDummy = 0;
    runSession(32'hAB123450, 3);
    check("R3 opcode", capCmd, 32'h03);
    check("R3 address", capAddr, 32'h00123450);
    regRead(6'h0C, d); check("R1 fill", d, 3);
    regRead(6'h1C, d); check("R8 xfer count", d, 3);
    regRead(6'h20, d); check("R8 current addr", d, 32'h0012345C);
    regRead(6'h14, d); check("R8 status idle", d, 0);
    check("R8 cs high", 32'(flashCsN), 1);
    checkWords("R6 default data", 32'h00123450, 3);
  endtask

  task automatic testFlex();
    flexEn = 1; cmdByte = 8'h6B; bitsPerCycle = 32'h0002_0002; bitsPerPhase = 32'd6;
    mCmdLog = 0; mAddrLog = 2; mDataLog = 2; mAddrBits = 24; mDummy = 6;
    runSession(32'h0000_2000, 4);
    check("R4 quad opcode", capCmd, 32'h6B);
    check("R4 quad address", capAddr, 32'h2000);
    checkWords("R4 quad data", 32'h2000, 4);
    cmdByte = 8'h3B; bitsPerCycle = 32'h0101_0001; bitsPerPhase = 32'd4;
    mCmdLog = 1; mAddrLog = 1; mDataLog = 1; mDummy = 4;
    runSession(32'h0004_1230, 2);
    check("R4 dual opcode", capCmd, 32'h3B);
    check("R4 dual address", capAddr, 32'h41230);
    checkWords("R6 dual data", 32'h41230, 2);
  endtask

  task automatic testFourByte();
    logic [31:0] d;
    flexEn = 1; cmdByte = 8'h0C; bitsPerCycle = 32'h0; bitsPerPhase = 32'h0001_0008;
    upperAddr = 8'h5A;
    mCmdLog = 0; mAddrLog = 0; mDataLog = 0; mAddrBits = 32; mDummy = 8;
    runSession(32'h77FF_FFF0, 4);
    check("R5 opcode", capCmd, 32'h0C);
    check("R5 address", capAddr, 32'h5AFF_FFF0);
    regRead(6'h20, d); check("R5 addr wrap", d, 32'h5A00_0000);
    checkWords("R5 data", 32'h5AFF_FFF0, 4);
    upperAddr = 8'h00;
  endtask

  task automatic testEmptyPop();
    logic [31:0] d;
    regRead(6'h18, d); check("R7 empty read zero", d, 0);
    regRead(6'h0C, d); check("R7 fill unchanged", d, 0);
    regRead(6'h14, d); check("R7 still empty", d, 32'h2);
  endtask

  task automatic testStartIgnored();
    logic [31:0] d;
    int falls;
    flexEn = 0; mCmdLog = 0; mAddrLog = 0; mDataLog = 0; mAddrBits = 24; mDummy = 0;
    falls = csFalls;
    regWrite(6'h04, 0);
    regWrite(6'h08, 1);
    repeat (10) @(negedge clk);
    check("R2 zero count no session", 32'(csFalls - falls), 0);
    regRead(6'h14, d); check("R2 zero count idle", d, 32'h2);
    regWrite(6'h00, 32'h300);
    regWrite(6'h04, 3);
    regWrite(6'h08, 1);
    repeat (20) @(negedge clk);
    regWrite(6'h04, 9);
    regWrite(6'h08, 1);
    waitIdle();
    regRead(6'h1C, d); check("R2 restart ignored xfer", d, 3);
    regRead(6'h0C, d); check("R2 restart ignored fill", d, 3);
    check("R2 one session", 32'(csFalls - falls), 1);
    checkWords("R2 data", 32'h300, 3);
  endtask

  task automatic testFullStall();
    logic [31:0] d;
    int highs = 0;
    flexEn = 0; mCmdLog = 0; mAddrLog = 0; mDataLog = 0; mAddrBits = 24; mDummy = 0;
    regWrite(6'h00, 32'h8000);
    regWrite(6'h04, 12);
    regWrite(6'h08, 1);
    for (int i = 0; i < 20000; i++) begin
      regRead(6'h0C, d);
      if (d == 8) break;
    end
    repeat (40) begin
      @(negedge clk);
      if (flashSclk) highs++;
    end
    check("R9 clock parked", 32'(highs), 0);
    regRead(6'h14, d); check("R9 busy while stalled", d, 32'h1);
    regRead(6'h0C, d); check("R9 fill held", d, 8);
    checkWords("R9 no loss", 32'h8000, 12);
    waitIdle();
    regRead(6'h1C, d); check("R9 all delivered", d, 12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testDefaultRead();
    testFlex();
    testFourByte();
    testEmptyPop();
    testStartIgnored();
    testFullStall();
    check("R10 sclk low while deselected", 32'(csViolations), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule